// File: doc/BRIEF.md
# Two-Digit Decimal Join Unit

This execution unit serves a byte-oriented processor core. It handles one two-byte instruction. The first byte is a fixed opcode and the second is an immediate radix. The unit folds a high digit and a low digit into one binary byte. The high digit is held in the upper accumulator byte and the low digit in the lower accumulator byte. The unit multiplies the high digit by the radix, adds the low digit, and writes the sum back into the lower byte. It then clears the upper byte.

The radix comes from the immediate byte. Assemblers normally emit ten, but any value is honoured and changes the result. All six arithmetic status flags are produced from the final 8-bit addition, following the usual rules for an integer add. This includes carry, auxiliary carry and overflow. The control flags, and every other bit of the flags word, pass through unchanged.

The core presents the two instruction bytes, the current accumulator halves and the current flags word, together with a valid strobe. One cycle later the unit returns registered results. If the opcode byte does not match, the unit raises an illegal indication and returns its inputs untouched.

Top module: `digit_join_unit`

## Requirements
- R1: Only a first instruction byte of 0xD5 is executed. Any other first byte sets `illegal` to 1 and returns `al_out`, `ah_out` and `flags_out` equal to the inputs of that transaction. For an executed instruction, `illegal` is 0.
- R2: An executed instruction returns `al_out` = (AL + AH * imm) mod 256 and `ah_out` = 0, for every immediate value including 0x0A, 0x00 and 0xFF.
- R3: Flags bit 0 (carry) equals the carry out of bit 7 of the 8-bit addition of AL and the low byte of AH * imm.
- R4: Flags bit 4 (auxiliary carry) equals the carry out of bit 3 of that same addition.
- R5: Flags bit 11 (overflow) is set when both addends of that addition have equal bit 7 and the sum's bit 7 differs from them.
- R6: Flags bit 7 (sign) equals bit 7 of `al_out`. Flags bit 6 (zero) is set when `al_out` is 0. Flags bit 2 (parity) is set when `al_out` has an even number of one bits.
- R7: All flags bits other than 0, 2, 4, 6, 7 and 11 equal the input flags word, including trap (bit 8), interrupt (bit 9) and direction (bit 10).
- R8: `out_valid` is 1 exactly in the cycle after a cycle with `in_valid` high. A cycle without `in_valid` leaves `al_out`, `ah_out`, `flags_out` and `illegal` holding their previous values.
- R9: While the synchronous active-high `rst` is high at a clock edge, all outputs are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction bytes and operands are present |
| op_byte | input | 8 | First instruction byte (opcode) |
| imm_byte | input | 8 | Second instruction byte (radix) |
| al_in | input | 8 | Current low accumulator byte (low digit) |
| ah_in | input | 8 | Current high accumulator byte (high digit) |
| flags_in | input | 16 | Current flags word |
| out_valid | output | 1 | Result registers updated this cycle |
| al_out | output | 8 | New low accumulator byte |
| ah_out | output | 8 | New high accumulator byte |
| flags_out | output | 16 | New flags word |
| illegal | output | 1 | Opcode byte did not match |

## Verification
Carry out of bit 7 and a zero result can occur in the same cycle. This happens when the addend and the product's low byte sum to exactly 256. A separate zero-detect path and a separate carry path must then agree with each other. Directed operands provoke it, for example AL 0x80, AH 0x01 and radix 0x80, where carry, zero, overflow and parity are all set together. Random operands then hit the wrap-to-zero case again. Every flag field is judged separately against a bench model of the addition, so an error in either path is reported under its own requirement.

// File: rtl/digit_join_pkg.sv
package digit_join_pkg;
    localparam int FLAG_CARRY  = 0;
    localparam int FLAG_PARITY = 2;
    localparam int FLAG_AUX    = 4;
    localparam int FLAG_ZERO   = 6;
    localparam int FLAG_SIGN   = 7;
    localparam int FLAG_TRAP   = 8;
    localparam int FLAG_INTR   = 9;
    localparam int FLAG_DIR    = 10;
    localparam int FLAG_OVF    = 11;
    localparam int NIBBLE_W    = 4;

    typedef struct packed {
        logic ovf;
        logic sign;
        logic zero;
        logic aux;
        logic parity;
        logic carry;
    } arith_flags_t;
endpackage

// File: rtl/digit_join_decode.sv
module digit_join_decode #(
    parameter int          OP_W   = 8,
    parameter logic [7:0]  OPCODE = 8'hD5
) (
    input  logic [OP_W-1:0] op_byte,
    output logic            is_legal
);
    localparam logic [OP_W-1:0] MATCH = OP_W'(OPCODE);

    always_comb begin
        is_legal = (op_byte == MATCH);
    end
endmodule

// File: rtl/digit_join_muladd.sv
module digit_join_muladd #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] low_digit,
    input  logic [DATA_W-1:0] high_digit,
    input  logic [DATA_W-1:0] radix,
    output logic [DATA_W-1:0] sum,
    output logic              carry_top,
    output logic              carry_nib,
    output logic              ovf
);
    import digit_join_pkg::*;

    localparam int PROD_W = 2 * DATA_W;

    logic [PROD_W-1:0]     product;
    logic [DATA_W-1:0]     scaled;
    logic [DATA_W:0]       wide_sum;
    logic [NIBBLE_W:0]     nib_sum;

    always_comb begin
        product   = PROD_W'(high_digit) * PROD_W'(radix);
        scaled    = product[DATA_W-1:0];
        wide_sum  = {1'b0, low_digit} + {1'b0, scaled};
        nib_sum   = {1'b0, low_digit[NIBBLE_W-1:0]} + {1'b0, scaled[NIBBLE_W-1:0]};
        sum       = wide_sum[DATA_W-1:0];
        carry_top = wide_sum[DATA_W];
        carry_nib = nib_sum[NIBBLE_W];
        ovf       = (low_digit[DATA_W-1] == scaled[DATA_W-1]) &&
                    (wide_sum[DATA_W-1] != low_digit[DATA_W-1]);
    end
endmodule

// File: rtl/digit_join_flaggen.sv
module digit_join_flaggen #(
    parameter int DATA_W = 8,
    parameter int FLAG_W = 16
) (
    input  logic [DATA_W-1:0] result,
    input  logic              carry_top,
    input  logic              carry_nib,
    input  logic              ovf,
    input  logic [FLAG_W-1:0] flags_in,
    output logic [FLAG_W-1:0] flags_out
);
    import digit_join_pkg::*;

    arith_flags_t af;
    logic [DATA_W-1:0] par_chain;

    genvar gi;
    generate
        for (gi = 0; gi < DATA_W; gi++) begin : g_par
            if (gi == 0) begin : g_first
                assign par_chain[gi] = result[gi];
            end else begin : g_next
                assign par_chain[gi] = par_chain[gi-1] ^ result[gi];
            end
        end
    endgenerate

    always_comb begin
        af.carry  = carry_top;
        af.aux    = carry_nib;
        af.ovf    = ovf;
        af.sign   = result[DATA_W-1];
        af.zero   = (result == '0);
        af.parity = ~par_chain[DATA_W-1];

        flags_out              = flags_in;
        flags_out[FLAG_CARRY]  = af.carry;
        flags_out[FLAG_PARITY] = af.parity;
        flags_out[FLAG_AUX]    = af.aux;
        flags_out[FLAG_ZERO]   = af.zero;
        flags_out[FLAG_SIGN]   = af.sign;
        flags_out[FLAG_OVF]    = af.ovf;
    end
endmodule

// File: rtl/digit_join_unit.sv
module digit_join_unit #(
    parameter int         DATA_W = 8,
    parameter int         FLAG_W = 16,
    parameter logic [7:0] OPCODE = 8'hD5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [7:0]        op_byte,
    input  logic [DATA_W-1:0] imm_byte,
    input  logic [DATA_W-1:0] al_in,
    input  logic [DATA_W-1:0] ah_in,
    input  logic [FLAG_W-1:0] flags_in,
    output logic              out_valid,
    output logic [DATA_W-1:0] al_out,
    output logic [DATA_W-1:0] ah_out,
    output logic [FLAG_W-1:0] flags_out,
    output logic              illegal
);
    typedef struct packed {
        logic              valid;
        logic              bad_op;
        logic [DATA_W-1:0] lo;
        logic [DATA_W-1:0] hi;
        logic [FLAG_W-1:0] flags;
    } result_t;

    result_t state_d, state_q;

    logic              op_ok;
    logic [DATA_W-1:0] join_sum;
    logic              c_top, c_nib, v_flag;
    logic [FLAG_W-1:0] new_flags;

    digit_join_decode #(.OP_W(8), .OPCODE(OPCODE)) i_decode (
        .op_byte  (op_byte),
        .is_legal (op_ok)
    );

    digit_join_muladd #(.DATA_W(DATA_W)) i_muladd (
        .low_digit  (al_in),
        .high_digit (ah_in),
        .radix      (imm_byte),
        .sum        (join_sum),
        .carry_top  (c_top),
        .carry_nib  (c_nib),
        .ovf        (v_flag)
    );

    digit_join_flaggen #(.DATA_W(DATA_W), .FLAG_W(FLAG_W)) i_flags (
        .result    (join_sum),
        .carry_top (c_top),
        .carry_nib (c_nib),
        .ovf       (v_flag),
        .flags_in  (flags_in),
        .flags_out (new_flags)
    );

    always_comb begin
        state_d       = state_q;
        state_d.valid = in_valid;
        if (in_valid) begin
            if (op_ok) begin
                state_d.bad_op = 1'b0;
                state_d.lo     = join_sum;
                state_d.hi     = '0;
                state_d.flags  = new_flags;
            end else begin
                state_d.bad_op = 1'b1;
                state_d.lo     = al_in;
                state_d.hi     = ah_in;
                state_d.flags  = flags_in;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = state_q.valid;
    assign illegal   = state_q.bad_op;
    assign al_out    = state_q.lo;
    assign ah_out    = state_q.hi;
    assign flags_out = state_q.flags;
endmodule

// File: rtl/digit_join_checker.sv
module digit_join_checker #(
    parameter int         DATA_W = 8,
    parameter int         FLAG_W = 16,
    parameter logic [7:0] OPCODE = 8'hD5
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [7:0]        op_byte,
    input logic [DATA_W-1:0] al_in,
    input logic [DATA_W-1:0] ah_in,
    input logic [FLAG_W-1:0] flags_in,
    input logic              out_valid,
    input logic [DATA_W-1:0] al_out,
    input logic [DATA_W-1:0] ah_out,
    input logic [FLAG_W-1:0] flags_out,
    input logic              illegal
);
    import digit_join_pkg::*;

    assert_valid_follows_R8: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_idle_no_valid_R8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_idle_holds_R8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(al_out) && $stable(ah_out) && $stable(flags_out) && $stable(illegal));

    assert_illegal_flag_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (illegal == ($past(op_byte) != OPCODE)));

    assert_illegal_pass_R1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_byte != OPCODE) |=>
            (al_out == $past(al_in)) && (ah_out == $past(ah_in)) && (flags_out == $past(flags_in)));

    assert_high_cleared_R2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !illegal) |-> (ah_out == '0));

    assert_result_flags_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !illegal) |->
            (flags_out[FLAG_ZERO] == (al_out == '0)) &&
            (flags_out[FLAG_SIGN] == al_out[DATA_W-1]) &&
            (flags_out[FLAG_PARITY] == ($countones(al_out) % 2 == 0)));

    assert_control_kept_R7: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> flags_out[FLAG_DIR:FLAG_TRAP] == $past(flags_in[FLAG_DIR:FLAG_TRAP]));
endmodule

bind digit_join_unit digit_join_checker #(
    .DATA_W(DATA_W), .FLAG_W(FLAG_W), .OPCODE(OPCODE)
) i_checker (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_byte(op_byte),
    .al_in(al_in), .ah_in(ah_in), .flags_in(flags_in),
    .out_valid(out_valid), .al_out(al_out), .ah_out(ah_out),
    .flags_out(flags_out), .illegal(illegal)
);

// File: tb/test_digit_join_unit.sv
module test_digit_join_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [7:0]  op_byte, imm_byte, al_in, ah_in;
    logic [15:0] flags_in;
    logic        out_valid, illegal;
    logic [7:0]  al_out, ah_out;
    logic [15:0] flags_out;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    digit_join_unit i_digit_join_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_byte(op_byte),
        .imm_byte(imm_byte), .al_in(al_in), .ah_in(ah_in), .flags_in(flags_in),
        .out_valid(out_valid), .al_out(al_out), .ah_out(ah_out),
        .flags_out(flags_out), .illegal(illegal)
    );

    // Returns {illegal, flags[15:0], ah[7:0], al[7:0]}
    function automatic logic [32:0] model(input logic [7:0] op, input logic [7:0] imm,
                                          input logic [7:0] lo, input logic [7:0] hi,
                                          input logic [15:0] fl);
        logic [15:0] prod;
        logic [7:0]  b;
        logic [8:0]  s;
        logic [4:0]  n;
        logic [15:0] f;
        int          ones;
        if (op != 8'hD5) return {1'b1, fl, hi, lo};
        prod = 16'(hi) * 16'(imm);
        b    = prod[7:0];
        s    = {1'b0, lo} + {1'b0, b};
        n    = {1'b0, lo[3:0]} + {1'b0, b[3:0]};
        ones = 0;
        for (int k = 0; k < 8; k++) ones += int'(s[k]);
        f     = fl;
        f[0]  = s[8];
        f[2]  = (ones % 2 == 0);
        f[4]  = n[4];
        f[6]  = (s[7:0] == 8'h00);
        f[7]  = s[7];
        f[11] = (lo[7] == b[7]) && (s[7] != lo[7]);
        return {1'b0, f, 8'h00, s[7:0]};
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_one(input logic [7:0] op, input logic [7:0] imm,
                           input logic [7:0] lo, input logic [7:0] hi,
                           input logic [15:0] fl);
        logic [32:0] e;
        e = model(op, imm, lo, hi, fl);
        in_valid = 1'b1; op_byte = op; imm_byte = imm;
        al_in = lo; ah_in = hi; flags_in = fl;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R8 out_valid", {15'd0, out_valid}, 16'd1);
        chk("R1 illegal", {15'd0, illegal}, {15'd0, e[32]});
        chk("R2 al_out", {8'd0, al_out}, {8'd0, e[7:0]});
        chk("R2 ah_out", {8'd0, ah_out}, {8'd0, e[15:8]});
        chk("R3 carry", {15'd0, flags_out[0]}, {15'd0, e[16]});
        chk("R4 aux", {15'd0, flags_out[4]}, {15'd0, e[20]});
        chk("R5 overflow", {15'd0, flags_out[11]}, {15'd0, e[27]});
        chk("R6 sign/zero/parity", {13'd0, flags_out[7], flags_out[6], flags_out[2]},
            {13'd0, e[23], e[22], e[18]});
        chk("R7 other flags", flags_out & 16'hF72A, e[31:16] & 16'hF72A);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] held;
        void'($urandom(32'd20240611));
        rst = 1'b1; in_valid = 1'b1; op_byte = 8'hD5; imm_byte = 8'h0A;
        al_in = 8'h55; ah_in = 8'h33; flags_in = 16'hFFFF;
        repeat (3) @(negedge clk);
        chk("R9 reset valid", {15'd0, out_valid}, 16'd0);
        chk("R9 reset regs", {al_out, ah_out}, 16'd0);
        chk("R9 reset flags", flags_out, 16'd0);
        chk("R9 reset illegal", {15'd0, illegal}, 16'd0);
        in_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);

        run_one(8'hD5, 8'h0A, 8'h03, 8'h07, 16'h0000); // R2 decimal 73
        chk("R2 decimal join", {8'd0, al_out}, 16'h0049);
        run_one(8'hD5, 8'h80, 8'h80, 8'h01, 16'h0700); // R3 with zero, wrap to 0
        run_one(8'hD5, 8'h01, 8'h0F, 8'h01, 16'h0000); // R4 nibble carry
        run_one(8'hD5, 8'h01, 8'h7F, 8'h01, 16'h0000); // R5 positive overflow
        run_one(8'hD5, 8'h00, 8'hA5, 8'hFF, 16'hFFFF); // R2 zero radix
        run_one(8'hD5, 8'hFF, 8'hFF, 8'hFF, 16'h0000); // R2 max operands
        run_one(8'hD4, 8'h0A, 8'h12, 8'h34, 16'h0A55); // R1 illegal pass-through

        held = {al_out, ah_out};
        in_valid = 1'b0; al_in = 8'h99; ah_in = 8'h11; op_byte = 8'hD5;
        @(negedge clk);
        chk("R8 idle valid low", {15'd0, out_valid}, 16'd0);
        chk("R8 idle hold", {al_out, ah_out}, held);

        for (int i = 0; i < 400; i++) begin
            logic [7:0] op;
            op = ($urandom % 8 == 0) ? 8'($urandom) : 8'hD5;
            run_one(op, 8'($urandom), 8'($urandom), 8'($urandom), 16'($urandom));
            if ($urandom % 4 == 0) @(negedge clk);
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule